// File: doc/BRIEF.md
# Split-Half Direct-Mapped Data Cache with Prefetch Tracking

This block holds the tag and fill state for a small direct-mapped data cache shared by several requesters. The physical address space is divided in two by its most significant bit, and each half owns a fixed group of lines that the other half can never use. A requester presents one request per cycle: a demand load or store, a non-blocking prefetch hint, or an invalidate. The block answers demand requests in the same cycle with a hit or a stall and starts line refills toward backing memory. A refill takes a fixed number of cycles, counted inside the block.

Each line allows only one refill at a time. A prefetch that would collide with a refill already under way is dropped. A demand miss may take over a line whose refill was started by a prefetch for some other block. Each line's resident tag, pending refill tag, valid and busy bits are driven out as status, so a requester or a bench can inspect them.

Top module: `pcache_top`

## Requirements
- R1: After reset every line is invalid and not busy, and `resp_hit`, `resp_stall` and `refill_start` are low while no request is presented.
- R2: The line for an address is {addr[31], addr[8]}. Addresses with bit 31 clear use lines 0 and 1 only, and addresses with bit 31 set use lines 2 and 3 only. The tag is addr[30:9]. `line_tag` and `fill_tag` report tags in this form.
- R3: A demand request has `req_kind` 0 (load) or 1 (store). A demand request whose block is resident and valid raises `resp_hit` in the same cycle, with `resp_stall` low and no refill started.
- R4: A demand miss on a line with no refill under way raises `resp_stall` and pulses `refill_start` with `refill_addr` equal to the request address. The block becomes valid and resident exactly FILL_LAT clock edges after the edge that accepted the miss, and stays busy and not valid before that edge.
- R5: A prefetch (`req_kind` 2) never raises `resp_stall` or `resp_hit`. A prefetch to an idle line whose block is not resident starts a refill, and the block becomes resident FILL_LAT edges later.
- R6: A prefetch is dropped, with no `refill_start` and `fill_tag` unchanged, when its line already has a refill under way from any request kind, or when the block is already resident.
- R7: A demand miss to a line whose pending refill was started by a prefetch for a different block restarts that refill for the demanded block. The prefetched block never becomes resident, and the new block becomes resident FILL_LAT edges after the takeover.
- R8: A demand request for the block already being refilled starts nothing new and stalls. A refill started by a demand, or joined by one, is not taken over by a later demand for another block; that request stalls with no `refill_start`.
- R9: An invalidate (`req_kind` 3) whose block is resident clears the line's valid bit on the next edge. An invalidate for a block that is neither resident nor being refilled leaves the line unchanged.
- R10: An invalidate for the block being refilled in its line cancels the refill and leaves the line invalid. The line stays invalid after the refill would have completed.
- R11: While a refill for another block is pending in a line, the old resident block stays valid and demand requests to it still hit.
- R12: Requests and refills in one line leave the valid bit, tag and busy state of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 prefetch, 3 invalidate |
| req_addr | input | ADDR_W | Physical byte address of the request |
| resp_hit | output | 1 | Demand request hits this cycle |
| resp_stall | output | 1 | Demand request must wait |
| refill_start | output | 1 | A refill toward backing memory begins this cycle |
| refill_addr | output | ADDR_W | Byte address whose enclosing block is fetched |
| line_valid | output | N_LINES | Per-line valid bit |
| line_busy | output | N_LINES | Per-line refill-in-progress bit |
| line_tag | output | N_LINES x TAG_W | Per-line resident tag |
| fill_tag | output | N_LINES x TAG_W | Per-line tag being refilled |

## Verification
On every cycle the assertions check that a hit and a stall never coincide, that prefetches never stall, that a prefetch into a busy line never starts a refill, that at most one line starts a refill, that a line only turns valid after being busy, and that a cancelled refill leaves its line idle and invalid. The ordering rules need the bench scenarios: the exact completion edge of a refill, a demand taking over a pending prefetch, a demand refusing to steal another demand's refill, and an old block still hitting during a pending refill. The bench also shows that invalidates for absent blocks leave a line intact and that activity in one line leaves the other lines untouched.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

  typedef enum logic [1:0] {
    RK_LOAD     = 2'd0,
    RK_STORE    = 2'd1,
    RK_PREFETCH = 2'd2,
    RK_INVAL    = 2'd3
  } req_kind_e;

  function automatic logic is_demand(input req_kind_e k);
    return (k == RK_LOAD) || (k == RK_STORE);
  endfunction

endpackage

// File: rtl/pcache_decode.sv
module pcache_decode #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8,
  parameter int IDX_W  = 1,
  localparam int LINE_W = IDX_W + 1,
  localparam int TAG_W  = ADDR_W - 1 - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:OFF_W] blk_i,
  output logic [LINE_W-1:0]     line_o,
  output logic [TAG_W-1:0]      tag_o
);

  // Partition bit on top, index bits of the half below it.
  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:OFF_W] b);
    return {b[ADDR_W-1], b[OFF_W +: IDX_W]};
  endfunction

  // Everything between the partition bit and the index bits.
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:OFF_W] b);
    return b[ADDR_W-2 : OFF_W+IDX_W];
  endfunction

  assign line_o = line_of(blk_i);
  assign tag_o  = tag_of(blk_i);

endmodule

// File: rtl/pcache_line.sv
module pcache_line
  import pcache_pkg::*;
#(
  parameter int TAG_W    = 22,
  parameter int FILL_LAT = 100,
  localparam int CNT_W = (FILL_LAT > 1) ? $clog2(FILL_LAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  req_kind_e        kind_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [TAG_W-1:0] ftag_o,
  output logic             ev_start_o,
  output logic             ev_cancel_o,
  output logic             ev_done_o
);

  logic             vld_q, busy_q, fdem_q;
  logic [TAG_W-1:0] tag_q, ftag_q;
  logic [CNT_W-1:0] cnt_q;

  logic dem, pf, inv;
  logic fill_match, dem_start, pf_start, drop_vld;

  assign dem = sel_i && is_demand(kind_i);
  assign pf  = sel_i && (kind_i == RK_PREFETCH);
  assign inv = sel_i && (kind_i == RK_INVAL);

  assign hit_o      = vld_q && (tag_q == tag_i);
  assign fill_match = busy_q && (ftag_q == tag_i);

  // Demand may start on an idle line or steal a prefetch-only refill.
  assign dem_start   = dem && !hit_o && (!busy_q || (!fdem_q && !fill_match));
  assign pf_start    = pf && !hit_o && !busy_q;
  assign ev_start_o  = dem_start || pf_start;
  assign ev_cancel_o = inv && fill_match;
  assign drop_vld    = inv && hit_o;
  assign ev_done_o   = busy_q && (cnt_q == '0) && !ev_start_o && !ev_cancel_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      busy_q <= 1'b0;
      fdem_q <= 1'b0;
      tag_q  <= '0;
      ftag_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (drop_vld) vld_q <= 1'b0;
      if (ev_start_o) begin
        busy_q <= 1'b1;
        fdem_q <= dem;
        ftag_q <= tag_i;
        cnt_q  <= CNT_W'(FILL_LAT - 1);
      end else if (ev_cancel_o) begin
        busy_q <= 1'b0;
        vld_q  <= 1'b0;
      end else if (ev_done_o) begin
        busy_q <= 1'b0;
        vld_q  <= 1'b1;
        tag_q  <= ftag_q;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (dem && fill_match) fdem_q <= 1'b1;
      end
    end
  end

  assign valid_o = vld_q;
  assign busy_o  = busy_q;
  assign tag_o   = tag_q;
  assign ftag_o  = ftag_q;

endmodule

// File: rtl/pcache_top.sv
module pcache_top
  import pcache_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LINE_BYTES     = 256,
  parameter int LINES_PER_HALF = 2,
  parameter int FILL_LAT       = 100,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(LINES_PER_HALF),
  localparam int LINE_W  = IDX_W + 1,
  localparam int N_LINES = 2 * LINES_PER_HALF,
  localparam int TAG_W   = ADDR_W - 1 - OFF_W - IDX_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [1:0]                      req_kind,
  input  logic [ADDR_W-1:0]               req_addr,
  output logic                            resp_hit,
  output logic                            resp_stall,
  output logic                            refill_start,
  output logic [ADDR_W-1:0]               refill_addr,
  output logic [N_LINES-1:0]              line_valid,
  output logic [N_LINES-1:0]              line_busy,
  output logic [N_LINES-1:0][TAG_W-1:0]   line_tag,
  output logic [N_LINES-1:0][TAG_W-1:0]   fill_tag
);

  req_kind_e          kind;
  logic [LINE_W-1:0]  req_line;
  logic [TAG_W-1:0]   req_tag;
  logic [N_LINES-1:0] sel_v, hit_v;
  logic [N_LINES-1:0] ev_start, ev_cancel, ev_done;
  logic               addr_hit, addr_busy, dem_req;

  assign kind = req_kind_e'(req_kind);

  pcache_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dec (
    .blk_i  (req_addr[ADDR_W-1:OFF_W]),
    .line_o (req_line),
    .tag_o  (req_tag)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign sel_v[i] = req_valid && (req_line == LINE_W'(i));

    pcache_line #(.TAG_W(TAG_W), .FILL_LAT(FILL_LAT)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_i       (sel_v[i]),
      .kind_i      (kind),
      .tag_i       (req_tag),
      .hit_o       (hit_v[i]),
      .valid_o     (line_valid[i]),
      .busy_o      (line_busy[i]),
      .tag_o       (line_tag[i]),
      .ftag_o      (fill_tag[i]),
      .ev_start_o  (ev_start[i]),
      .ev_cancel_o (ev_cancel[i]),
      .ev_done_o   (ev_done[i])
    );
  end

  assign addr_hit  = |(sel_v & hit_v);
  assign addr_busy = |(sel_v & line_busy);
  assign dem_req   = req_valid && is_demand(kind);

  assign resp_hit     = dem_req && addr_hit;
  assign resp_stall   = dem_req && !addr_hit;
  assign refill_start = |ev_start;
  assign refill_addr  = req_addr;

endmodule

// File: rtl/pcache_chk.sv
module pcache_chk #(
  parameter int N_LINES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_kind,
  input logic               resp_hit,
  input logic               resp_stall,
  input logic               refill_start,
  input logic               addr_busy,
  input logic [N_LINES-1:0] line_valid,
  input logic [N_LINES-1:0] line_busy,
  input logic [N_LINES-1:0] ev_start,
  input logic [N_LINES-1:0] ev_cancel
);

  a_r3_hit_excludes_stall: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> !resp_stall);

  a_r5_prefetch_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2) |-> (!resp_stall && !resp_hit));

  a_r6_busy_drops_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2 && addr_busy) |-> !refill_start);

  a_r12_single_line_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_start));

  for (genvar i = 0; i < N_LINES; i++) begin : g_per_line
    a_r4_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_valid[i]) |-> $past(line_busy[i]));

    a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start[i] |=> line_busy[i]);

    a_r10_cancel_idles_line: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cancel[i] |=> (!line_busy[i] && !line_valid[i]));
  end

endmodule

bind pcache_top pcache_chk #(.N_LINES(N_LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_kind     (req_kind),
  .resp_hit     (resp_hit),
  .resp_stall   (resp_stall),
  .refill_start (refill_start),
  .addr_busy    (addr_busy),
  .line_valid   (line_valid),
  .line_busy    (line_busy),
  .ev_start     (ev_start),
  .ev_cancel    (ev_cancel)
);

// File: tb/sim_pcache_top.sv
module sim_pcache_top;

  localparam int LAT = 8;
  localparam int AW  = 32;
  localparam int TW  = 22;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, req_valid;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic          resp_hit, resp_stall, refill_start;
  logic [AW-1:0] refill_addr;
  logic [3:0]    line_valid, line_busy;
  logic [3:0][TW-1:0] line_tag, fill_tag;

  pcache_top #(.FILL_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .resp_hit(resp_hit), .resp_stall(resp_stall),
    .refill_start(refill_start), .refill_addr(refill_addr),
    .line_valid(line_valid), .line_busy(line_busy),
    .line_tag(line_tag), .fill_tag(fill_tag)
  );

  int checks = 0;
  int errors = 0;

  // Address, expected line, request kind.
  localparam logic [35:0] VEC [0:3] = '{
    {32'h0000_0000, 2'd0, 2'd0},
    {32'h1234_5100, 2'd1, 2'd0},
    {32'h8000_0000, 2'd2, 2'd0},
    {32'hFEDC_BB37, 2'd3, 2'd1}
  };

  function automatic logic [TW-1:0] exp_tag(input logic [AW-1:0] a);
    return TW'(a >> 9);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      #1;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    chk("R1", "valid", 64'(line_valid), 64'h0);
    chk("R1", "busy", 64'(line_busy), 64'h0);
    chk("R1", "outputs", {61'h0, resp_hit, resp_stall, refill_start}, 64'h0);

    // Cold misses into each line, then hits (R2, R3, R4).
    for (int e = 0; e < 4; e++) begin
      logic [AW-1:0] a;
      int ln;
      a  = VEC[e][35:4];
      ln = int'(VEC[e][3:2]);
      issue(VEC[e][1:0], a);
      chk("R4", "miss stall", 64'(resp_stall), 64'h1);
      chk("R4", "refill start", 64'(refill_start), 64'h1);
      chk("R4", "refill addr", 64'(refill_addr), 64'(a));
      idle(LAT);
      chk("R4", "not yet valid", 64'(line_valid[ln]), 64'h0);
      idle(1);
      chk("R4", "valid at latency", 64'(line_valid[ln]), 64'h1);
      chk("R2", "resident tag", 64'(line_tag[ln]), 64'(exp_tag(a)));
      issue(2'd0, a);
      chk("R3", "hit", {62'h0, resp_hit, resp_stall}, 64'h2);
      chk("R3", "no refill on hit", 64'(refill_start), 64'h0);
    end

    // Prefetch behind a resident block, then takeover (R11, R6, R7, R12).
    issue(2'd2, 32'h0000_0200);
    chk("R5", "prefetch no wait", {62'h0, resp_hit, resp_stall}, 64'h0);
    chk("R5", "prefetch starts", 64'(refill_start), 64'h1);
    issue(2'd0, 32'h0000_0010);
    chk("R11", "old block hits", 64'(resp_hit), 64'h1);
    chk("R11", "fill pending tag", 64'(fill_tag[0]), 64'h1);
    issue(2'd2, 32'h0000_0400);
    chk("R6", "prefetch on busy dropped", 64'(refill_start), 64'h0);
    idle(1);
    chk("R6", "fill tag kept", 64'(fill_tag[0]), 64'h1);
    issue(2'd0, 32'h0000_0400);
    chk("R7", "takeover stalls", 64'(resp_stall), 64'h1);
    chk("R7", "takeover starts", 64'(refill_start), 64'h1);
    idle(LAT - 1);
    chk("R7", "prefetched block not resident", 64'(line_tag[0]), 64'h0);
    chk("R7", "new fill tag", 64'(fill_tag[0]), 64'h2);
    idle(2);
    chk("R7", "demanded block resident", {62'h0, line_valid[0], line_busy[0]}, 64'h2);
    chk("R7", "resident tag", 64'(line_tag[0]), 64'h2);
    chk("R12", "other lines valid", 64'(line_valid[3:1]), 64'h7);
    chk("R12", "line1 tag kept", 64'(line_tag[1]), 64'(exp_tag(32'h1234_5100)));

    // Demand-owned refill is not stolen (R8).
    issue(2'd0, 32'h0000_0600);
    chk("R8", "demand starts", 64'(refill_start), 64'h1);
    issue(2'd0, 32'h0000_0800);
    chk("R8", "other demand stalls", 64'(resp_stall), 64'h1);
    chk("R8", "other demand no start", 64'(refill_start), 64'h0);
    issue(2'd0, 32'h0000_06F0);
    chk("R8", "same block no restart", {62'h0, resp_stall, refill_start}, 64'h2);
    issue(2'd2, 32'h0000_0800);
    chk("R6", "prefetch on demand fill dropped", 64'(refill_start), 64'h0);
    idle(1);
    chk("R8", "fill tag kept", 64'(fill_tag[0]), 64'h3);
    idle(LAT - 3);
    chk("R8", "demanded block resident", 64'(line_tag[0]), 64'h3);
    chk("R8", "line valid idle", {62'h0, line_valid[0], line_busy[0]}, 64'h2);

    // Invalidate (R9).
    issue(2'd3, 32'h0000_06FF);
    chk("R9", "inval no response", {61'h0, resp_hit, resp_stall, refill_start}, 64'h0);
    idle(1);
    chk("R9", "resident cleared", 64'(line_valid[0]), 64'h0);
    issue(2'd3, 32'h1234_5300);
    idle(1);
    chk("R9", "absent block leaves line", 64'(line_valid[1]), 64'h1);
    issue(2'd0, 32'h1234_5100);
    chk("R9", "line1 still hits", 64'(resp_hit), 64'h1);

    // Invalidate of a filling block (R10).
    issue(2'd2, 32'h8000_0200);
    chk("R10", "prefetch starts", 64'(refill_start), 64'h1);
    issue(2'd3, 32'h8000_0210);
    chk("R10", "inval no start", 64'(refill_start), 64'h0);
    idle(1);
    chk("R10", "cancelled", {62'h0, line_valid[2], line_busy[2]}, 64'h0);
    idle(LAT + 1);
    chk("R10", "stays invalid", {62'h0, line_valid[2], line_busy[2]}, 64'h0);

    // Prefetch into an empty line (R5, R6).
    issue(2'd2, 32'h0000_0A00);
    chk("R5", "prefetch no wait", {62'h0, resp_hit, resp_stall}, 64'h0);
    chk("R5", "prefetch refill addr", 64'(refill_addr), 64'h0A00);
    idle(LAT);
    chk("R5", "busy before latency", {62'h0, line_valid[0], line_busy[0]}, 64'h1);
    idle(1);
    chk("R5", "resident after latency", 64'(line_tag[0]), 64'h5);
    chk("R5", "valid after latency", 64'(line_valid[0]), 64'h1);
    issue(2'd2, 32'h0000_0A80);
    chk("R6", "resident prefetch dropped", 64'(refill_start), 64'h0);
    issue(2'd0, 32'h0000_0A04);
    chk("R5", "prefetched block hits", 64'(resp_hit), 64'h1);
    idle(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule